// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block watches the synchronised levels of one bank of general-purpose pins, organised as four ports of eight pins, and turns configured pin events into pending-status bits and one bank interrupt line. Every pin has its own trigger choice: rising edge, falling edge, either edge, high level or low level. A pin's status bit latches when its condition is seen. The bank interrupt is high while any pin has both its status bit and its enable bit set.

Software reaches the block through a simple single-cycle register port. A write is a one-cycle `wr_en` pulse with address and data. A read is combinational from `rd_addr`. There is no streaming data path, so no valid/ready handshake and no back-pressure. Pin levels are assumed to be already synchronised and filtered before they arrive.

Addresses are byte addresses. Bits [1:0] must be zero and bits above 7 must be zero. Bits [3:2] select the port. Bits [6:4] select the register group: 4 is status, 5 is enable, 6 is trigger, 7 is clear. Bit 7 selects the masked alias of status, enable or trigger. The trigger word is three planes of eight bits: bits [7:0] hold polarity, bits [15:8] hold edge mode and bits [23:16] hold both-edge.

Top module: `gpio_irq_bank`

## Requirements
- R1: While reset is held, status, enable and trigger of every port read as zero and `bank_irq` is low.
- R2: Trigger value 0x000101 shifted by pin n selects rising edge. Status bit n sets in the cycle after a low-to-high change of the pin. It then holds, even when the pin falls, until it is cleared.
- R3: Trigger value 0x000100 shifted by pin n selects falling edge. Status bit n sets on a high-to-low change and then holds.
- R4: Trigger value 0x010100 shifted by pin n selects both edges. Status bit n sets on either change of the pin.
- R5: Trigger value 0x000001 shifted by pin n selects high level. Status bit n sets while the pin is high and sets again after a clear for as long as the pin stays high. After the pin drops, the bit stays set until it is cleared.
- R6: Trigger value 0x000000 selects low level. Status bit n sets while the pin is low.
- R7: Writing to the clear register (group 7) clears status bit n for each data bit n that is 1. Bits written as 0 change nothing. The clear register reads as zero. Status never drops without a write.
- R8: When a detection and a clear for the same pin fall in the same cycle, the status bit ends up set.
- R9: `bank_irq` is the OR over all 32 pins of status AND enable. Status bits latch whether or not the pin is enabled.
- R10: A write to the masked enable alias uses data bits [15:8] as a per-pin mask and bits [7:0] as new values. Pins whose mask bit is 0 keep their enable bit.
- R11: A write to the masked status alias uses bits [15:8] as mask and bits [7:0] as values to set or clear status bits. A plain write to the status register has no effect.
- R12: A write to the masked trigger alias uses data bits [31:24] as a per-pin mask. It loads all three planes from bits [23:0] for the selected pins only.
- R13: The registers sit at status 0x40, enable 0x50, trigger 0x60 and clear 0x70, each plus port*4. The masked aliases are 0x80 higher. A masked alias reads the same as its plain register. Addresses with any of bits [11:8] set are ignored on write and read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_level | input | 32 | Synchronised pin levels; bit port*8+pin |
| wr_en | input | 1 | One-cycle register write strobe |
| wr_addr | input | 12 | Register write byte address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 12 | Register read byte address |
| rd_data | output | 32 | Combinational read data |
| bank_irq | output | 1 | Bank interrupt, OR of enabled pending pins |

## Verification
The bench targets a clear and an edge landing in the same cycle. A design that gives priority to the clear would lose that edge and leave status at zero. It checks that a level-mode pin sets again straight after a clear, and that it stays latched once the level goes away. A design that lets status simply follow the pin would fail both checks. It checks that masked writes leave unmasked pins untouched, and that writes to the read-only status address or to out-of-range addresses change nothing. A design with a sloppy decode would corrupt a neighbouring register in those cases.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;

  localparam logic [2:0] GRP_STATUS  = 3'd4;
  localparam logic [2:0] GRP_ENABLE  = 3'd5;
  localparam logic [2:0] GRP_TRIGGER = 3'd6;
  localparam logic [2:0] GRP_CLEAR   = 3'd7;

  typedef struct packed {
    logic st_mwr;
    logic en_wr;
    logic en_mwr;
    logic tr_wr;
    logic tr_mwr;
    logic clr_wr;
  } port_wr_t;
endpackage

// File: rtl/gpio_irq_decode.sv
module gpio_irq_decode
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4
) (
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  output port_wr_t [NUM_PORTS-1:0]   strobes
);
  logic       hit;
  logic       upper;
  logic [2:0] grp;

  assign hit   = wr_en && (wr_addr[ADDR_W-1:8] == '0) && (wr_addr[1:0] == 2'b00);
  assign upper = wr_addr[7];
  assign grp   = wr_addr[6:4];

  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      logic sel;
      sel = hit && (wr_addr[3:2] == 2'(p));
      strobes[p].st_mwr = sel &&  upper && (grp == GRP_STATUS);
      strobes[p].en_wr  = sel && !upper && (grp == GRP_ENABLE);
      strobes[p].en_mwr = sel &&  upper && (grp == GRP_ENABLE);
      strobes[p].tr_wr  = sel && !upper && (grp == GRP_TRIGGER);
      strobes[p].tr_mwr = sel &&  upper && (grp == GRP_TRIGGER);
      strobes[p].clr_wr = sel && !upper && (grp == GRP_CLEAR);
    end
  end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int unsigned PINS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PINS-1:0]      pins,
  input  port_wr_t             wr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [PINS-1:0]      status,
  output logic [PINS-1:0]      enable,
  output logic [3*PINS-1:0]    trigger,
  output logic [PINS-1:0]      detect
);
  localparam int unsigned TW = 3 * PINS;

  logic [PINS-1:0] prev_q, status_q, enable_q, status_d, enable_d;
  logic [TW-1:0]   trig_q, trig_d;
  logic [PINS-1:0] pol, edg, both, rise, fall;
  logic [PINS-1:0] wmask, wval, tmask;
  logic [TW-1:0]   tmask3;

  assign pol   = trig_q[PINS-1:0];
  assign edg   = trig_q[2*PINS-1:PINS];
  assign both  = trig_q[TW-1:2*PINS];
  assign rise  = pins & ~prev_q;
  assign fall  = ~pins & prev_q;
  assign wval  = wdata[PINS-1:0];
  assign wmask = wdata[2*PINS-1:PINS];
  assign tmask = wdata[TW+PINS-1:TW];
  assign tmask3 = {3{tmask}};

  always_comb begin
    for (int i = 0; i < PINS; i++) begin
      if (edg[i])
        detect[i] = both[i] ? (rise[i] | fall[i]) : (pol[i] ? rise[i] : fall[i]);
      else
        detect[i] = pol[i] ? pins[i] : ~pins[i];
    end
  end

  always_comb begin
    status_d = status_q;
    if (wr.clr_wr) status_d = status_d & ~wval;
    if (wr.st_mwr) status_d = (status_d & ~wmask) | (wval & wmask);
    status_d = status_d | detect;

    enable_d = enable_q;
    if (wr.en_wr)  enable_d = wval;
    if (wr.en_mwr) enable_d = (enable_q & ~wmask) | (wval & wmask);

    trig_d = trig_q;
    if (wr.tr_wr)  trig_d = wdata[TW-1:0];
    if (wr.tr_mwr) trig_d = (trig_q & ~tmask3) | (wdata[TW-1:0] & tmask3);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      status_q <= '0;
      enable_q <= '0;
      trig_q   <= '0;
    end else begin
      prev_q   <= pins;
      status_q <= status_d;
      enable_q <= enable_d;
      trig_q   <= trig_d;
    end
  end

  assign status  = status_q;
  assign enable  = enable_q;
  assign trigger = trig_q;
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned PORT_PINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       pin_level,
  input  logic              wr_en,
  input  logic [11:0]       wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [11:0]       rd_addr,
  output logic [31:0]       rd_data,
  output logic              bank_irq
);
  localparam int unsigned NBITS = NUM_PORTS * PORT_PINS;
  localparam int unsigned TW    = 3 * PORT_PINS;

  port_wr_t [NUM_PORTS-1:0] strobes;
  logic [PORT_PINS-1:0] status_p  [NUM_PORTS];
  logic [PORT_PINS-1:0] enable_p  [NUM_PORTS];
  logic [TW-1:0]        trigger_p [NUM_PORTS];
  logic [NBITS-1:0]     status_all, enable_all, det_all, clr_all;
  logic                 unused_rd_up;

  gpio_irq_decode #(.NUM_PORTS(NUM_PORTS)) u_decode (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .strobes (strobes)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    gpio_irq_port #(.PINS(PORT_PINS)) u_port (
      .clk     (clk),
      .rst_n   (rst_n),
      .pins    (pin_level[p*PORT_PINS +: PORT_PINS]),
      .wr      (strobes[p]),
      .wdata   (wr_data),
      .status  (status_p[p]),
      .enable  (enable_p[p]),
      .trigger (trigger_p[p]),
      .detect  (det_all[p*PORT_PINS +: PORT_PINS])
    );
    assign status_all[p*PORT_PINS +: PORT_PINS] = status_p[p];
    assign enable_all[p*PORT_PINS +: PORT_PINS] = enable_p[p];
    assign clr_all[p*PORT_PINS +: PORT_PINS] =
      {PORT_PINS{strobes[p].clr_wr}} & wr_data[PORT_PINS-1:0];
  end

  assign bank_irq     = |(status_all & enable_all);
  assign unused_rd_up = rd_addr[7];

  always_comb begin
    rd_data = '0;
    if ((rd_addr[11:8] == 4'h0) && (rd_addr[1:0] == 2'b00) &&
        (int'(rd_addr[3:2]) < NUM_PORTS)) begin
      case (rd_addr[6:4])
        GRP_STATUS:  rd_data[PORT_PINS-1:0] = status_p[rd_addr[3:2]];
        GRP_ENABLE:  rd_data[PORT_PINS-1:0] = enable_p[rd_addr[3:2]];
        GRP_TRIGGER: rd_data[TW-1:0]        = trigger_p[rd_addr[3:2]];
        default:     rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_bank_checker.sv
module gpio_irq_bank_checker #(
  parameter int unsigned NBITS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             bank_irq,
  input logic [NBITS-1:0] status_all,
  input logic [NBITS-1:0] enable_all,
  input logic [NBITS-1:0] det_all,
  input logic [NBITS-1:0] clr_all
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (status_all == '0) && (enable_all == '0));

  assert_status_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((status_all & $past(status_all)) == $past(status_all)));

  assert_clear_effect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_all & ~det_all) != '0) |=> ((status_all & $past(clr_all & ~det_all)) == '0));

  assert_detect_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (det_all != '0) |=> ((status_all & $past(det_all)) == $past(det_all)));

  assert_irq_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bank_irq) |-> $past(wr_en));
endmodule

bind gpio_irq_bank gpio_irq_bank_checker #(.NBITS(NUM_PORTS * PORT_PINS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .bank_irq   (bank_irq),
  .status_all (status_all),
  .enable_all (enable_all),
  .det_all    (det_all),
  .clr_all    (clr_all)
);

// File: tb/gpio_irq_bank_test.sv
module gpio_irq_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pin_level = 32'hFFFF_FFFF;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [11:0] rd_addr = 12'h040;
  logic [31:0] rd_data;
  logic        bank_irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  gpio_irq_bank uut (
    .clk(clk), .rst_n(rst_n), .pin_level(pin_level),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .bank_irq(bank_irq)
  );

  // behavioural reference: one entry per pin
  bit [31:0] m_st, m_en, m_prev, m_det;
  bit [2:0]  m_tr [32];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = '0; m_en = '0; m_prev = '0;
      for (int i = 0; i < 32; i++) m_tr[i] = 3'b000;
    end else begin
      for (int i = 0; i < 32; i++) begin
        bit pin, pv;
        pin = pin_level[i]; pv = m_prev[i];
        if (m_tr[i][1]) begin
          if (m_tr[i][2])      m_det[i] = (pin != pv);
          else if (m_tr[i][0]) m_det[i] = pin && !pv;
          else                 m_det[i] = !pin && pv;
        end else begin
          m_det[i] = m_tr[i][0] ? pin : !pin;
        end
      end
      if (wr_en && wr_addr[11:8] == 0 && wr_addr[1:0] == 0) begin
        for (int b = 0; b < 8; b++) begin
          int i;
          i = int'(wr_addr[3:2]) * 8 + b;
          case ({wr_addr[7], wr_addr[6:4]})
            4'h5: m_en[i] = wr_data[b];
            4'hD: if (wr_data[8+b]) m_en[i] = wr_data[b];
            4'h6: m_tr[i] = {wr_data[16+b], wr_data[8+b], wr_data[b]};
            4'hE: if (wr_data[24+b]) m_tr[i] = {wr_data[16+b], wr_data[8+b], wr_data[b]};
            4'h7: if (wr_data[b]) m_st[i] = 1'b0;
            4'hC: if (wr_data[8+b]) m_st[i] = wr_data[b];
            default: ;
          endcase
        end
      end
      m_st = m_st | m_det;
      m_prev = pin_level;
    end
  end

  function automatic logic [31:0] mread(input logic [11:0] a);
    logic [31:0] r;
    int base;
    r = '0;
    base = int'(a[3:2]) * 8;
    if (a[11:8] == 0 && a[1:0] == 0) begin
      for (int b = 0; b < 8; b++) begin
        case (a[6:4])
          3'd4: r[b] = m_st[base+b];
          3'd5: r[b] = m_en[base+b];
          3'd6: begin
            r[b] = m_tr[base+b][0]; r[8+b] = m_tr[base+b][1]; r[16+b] = m_tr[base+b][2];
          end
          default: ;
        endcase
      end
    end
    return r;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the reference, between clock edges
  always begin
    @(negedge clk); #2;
    if (rst_n && !finished) begin
      chk({31'd0, bank_irq}, {31'd0, |(m_st & m_en)}, "R9 irq vs model");
      chk(rd_data, mread(rd_addr), "R13 readback vs model");
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pins(input logic [31:0] v);
    @(negedge clk);
    pin_level = v;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    // R1: reset state, read while reset is held
    idle(2);
    rd(12'h040, d); chk(d, 32'h0, "R1 status reset");
    rd(12'h050, d); chk(d, 32'h0, "R1 enable reset");
    rd(12'h060, d); chk(d, 32'h0, "R1 trigger reset");
    chk({31'd0, bank_irq}, 32'h0, "R1 irq reset");
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    rd(12'h040, d); chk(d, 32'h0, "R1 status after release");

    // R2: rising on port 0 pin 3
    wr(12'h060, 32'h0000_0808);
    pins(32'hFFFF_FFF7); idle(1);
    rd(12'h040, d); chk(d, 32'h0, "R2 no set on fall");
    pins(32'hFFFF_FFFF); idle(1);
    rd(12'h040, d); chk(d, 32'h08, "R2 set on rise");

    // R7: clear semantics
    wr(12'h070, 32'h0);
    rd(12'h040, d); chk(d, 32'h08, "R7 zero write no effect");
    rd(12'h070, d); chk(d, 32'h0, "R7 clear reads zero");
    wr(12'h070, 32'h08);
    rd(12'h040, d); chk(d, 32'h0, "R7 one clears");

    // R3: falling on port 1 pin 5
    wr(12'h064, 32'h0000_2000);
    pins(32'hFFFF_DFFF); idle(1);
    rd(12'h044, d); chk(d, 32'h20, "R3 set on fall");
    pins(32'hFFFF_FFFF); idle(1);
    rd(12'h044, d); chk(d, 32'h20, "R3 held after rise");

    // R4: both edges on port 2 pin 0
    wr(12'h068, 32'h0001_0100);
    pins(32'hFFFE_FFFF); idle(1);
    rd(12'h048, d); chk(d, 32'h01, "R4 set on fall");
    wr(12'h070 + 12'h008, 32'h01);
    pins(32'hFFFF_FFFF); idle(1);
    rd(12'h048, d); chk(d, 32'h01, "R4 set on rise");

    // R5: high level on port 3 pin 1 (pin already high)
    wr(12'h06C, 32'h0000_0002);
    idle(1);
    rd(12'h04C, d); chk(d, 32'h02, "R5 level high sets");
    wr(12'h07C, 32'h02);
    rd(12'h04C, d); chk(d, 32'h02, "R5 reasserts after clear");
    pins(32'hFDFF_FFFF); idle(1);
    rd(12'h04C, d); chk(d, 32'h02, "R5 held after level drop");
    wr(12'h07C, 32'h02);
    rd(12'h04C, d); chk(d, 32'h00, "R5 cleared after drop");

    // R6: low level on port 3 (all pins), pin 25 low
    wr(12'h06C, 32'h0);
    idle(1);
    rd(12'h04C, d); chk(d, 32'h02, "R6 low level sets");
    pins(32'hFFFF_FFFF);
    wr(12'h07C, 32'hFF);
    rd(12'h04C, d); chk(d, 32'h00, "R6 cleared with pin high");

    // R8: edge and clear in the same cycle, port 0 pin 3 rising
    pins(32'hFFFF_FFF7); idle(1);
    @(negedge clk);
    pin_level = 32'hFFFF_FFFF;
    wr_en = 1'b1; wr_addr = 12'h070; wr_data = 32'h08;
    @(negedge clk);
    wr_en = 1'b0;
    rd(12'h040, d); chk(d, 32'h08, "R8 detection wins over clear");

    // R9: enable gates the irq only
    chk({31'd0, bank_irq}, 32'h0, "R9 latched but disabled");
    wr(12'h050, 32'h08);
    chk({31'd0, bank_irq}, 32'h1, "R9 irq on enable");
    wr(12'h070, 32'h08);
    chk({31'd0, bank_irq}, 32'h0, "R9 irq off after clear");

    // R10: masked enable
    wr(12'h0D0, 32'h0000_0301);
    rd(12'h050, d); chk(d, 32'h09, "R10 masked enable");

    // R11: masked status, plain status write ignored
    wr(12'h0C0, 32'h0000_4040);
    rd(12'h040, d); chk(d, 32'h40, "R11 masked status set");
    wr(12'h040, 32'hFF);
    rd(12'h040, d); chk(d, 32'h40, "R11 plain status write ignored");
    wr(12'h0C0, 32'h0000_4000);
    rd(12'h040, d); chk(d, 32'h00, "R11 masked status clear");

    // R12: masked trigger, pin 7 rising
    wr(12'h0E0, 32'h8000_8080);
    rd(12'h060, d); chk(d, 32'h0000_8888, "R12 masked trigger");

    // R13: map and out-of-range addresses
    wr(12'h058, 32'hAA);
    rd(12'h058, d); chk(d, 32'hAA, "R13 enable port 2");
    rd(12'h0D8, d); chk(d, 32'hAA, "R13 alias readback");
    wr(12'h150, 32'hFF);
    rd(12'h050, d); chk(d, 32'h09, "R13 high address ignored");
    rd(12'h150, d); chk(d, 32'h0, "R13 high address reads zero");

    idle(3);
    finished = 1;
    summary();
    $finish;
  end
endmodule